// File: doc/BRIEF.md
# Virtual Interrupt Event Aggregator

This block collects event messages that each carry a global event number. A programmable map, loaded through its own configuration write port, binds each event number to a single status bit of one virtual interrupt (vint). Each vint holds 64 event bits, a 64-bit enable register and a 64-bit status register. Each vint drives one level interrupt line toward its parent. The line is high while any enabled status bit is set.

Software reaches each vint through a 4 KiB register page on a simple 64-bit register bus. The page gives write-one-to-set and write-one-to-clear access to the enables, a raw status view that software acknowledges by writing ones, and a read-only view of the status ANDed with the enables. Software scans the masked view to find pending events. A level-type source raises its bit with an up event and drops it with a later down event, so software never has to acknowledge it. An edge-type source sets its bit, and the bit stays set until software clears it.

Top module: `vint_aggregator`

## Requirements
- R1: A register write at page offset 0x0 ORs the write data into that vint's enables, so zero data bits leave enables unchanged. Reads at offset 0x0 or 0x8 return the current enables.
- R2: A register write at page offset 0x8 clears every enable bit that is 1 in the write data.
- R3: Page offset 0x18 reads the raw status. A write there clears every status bit that is 1 in the write data.
- R4: Page offset 0x20 reads the raw status ANDed with the enables. Writes to it change nothing.
- R5: Address bits [ADDR_W-1:12] select the vint, so vint n occupies bytes n*0x1000 to n*0x1000+0xFFF. Bits [11:0] select the register.
- R6: A configuration write stores {valid, level, vint, bit} at entry cfgIdx. An up event (evtDown=0) whose entry is valid sets the mapped status bit on the clock edge that samples it. For an edge-type entry (cfgLevel=0), a down event (evtDown=1) has no effect.
- R7: For a level-type entry (cfgLevel=1), an up event sets the mapped bit and a down event clears it.
- R8: An event whose entry is not valid, or whose entry names a vint at or beyond NUM_VINT, changes no status. Such an event raises evtError for exactly the cycle after it is sampled.
- R9: vintIrq[n] is the OR of vint n's masked status, delayed by one register. It rises or falls only one cycle after a status or enable change.
- R10: If an event set and a software write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Reads of offsets other than 0x0, 0x8, 0x18 and 0x20, or of pages at or beyond NUM_VINT, return zero. Writes to them change nothing.
- R12: After reset, all map entries, enables, status bits, interrupt lines and evtError are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | An event message is present this cycle |
| evtNum | input | EVT_W | Global event number of the message |
| evtDown | input | 1 | 0 = up event, 1 = down event |
| cfgWrEn | input | 1 | Write one map entry |
| cfgIdx | input | EVT_W | Map entry index (event number) |
| cfgValid | input | 1 | Entry valid flag |
| cfgLevel | input | 1 | 1 = level type, 0 = edge type |
| cfgVint | input | 8 | Target vint index |
| cfgBit | input | 6 | Target status bit within the vint |
| regAddr | input | ADDR_W | Register byte address (page and offset) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Read data for regAddr, combinational |
| vintIrq | output | NUM_VINT | One level interrupt line per vint |
| evtError | output | 1 | One-cycle pulse for a dropped event |

## Verification
The assertions check four things on every cycle. evtError only follows an event. Any change on an interrupt line traces back to a register write or an event two cycles earlier. Unimplemented offsets read zero. Pages beyond the vint count read zero. Only the bench's scenarios can show the mapping itself. They cover the edge/level difference on down events, set beating acknowledge in the same cycle, and page separation between vints. A behavioural model compares the interrupt lines and the error pulse on every clock and checks the value of each register read.

// File: rtl/vagg_pkg.sv
package vagg_pkg;
  localparam int IDX_W = 8;
  localparam int BIT_W = 6;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {RD_NONE, RD_ENABLE, RD_RAW, RD_MASKED} rdsel_e;

  typedef struct packed {
    logic             valid;
    logic             level;
    logic [IDX_W-1:0] vint;
    logic [BIT_W-1:0] bitIdx;
  } map_t;

  typedef struct packed {
    logic             evtSet;
    logic             evtClr;
    logic [IDX_W-1:0] evtVint;
    logic [BIT_W-1:0] evtBit;
    logic             enSet;
    logic             enClr;
    logic             ack;
    rdsel_e           rdSel;
    logic [IDX_W-1:0] pageVint;
  } strobe_t;
endpackage

// File: rtl/vagg_ctrl.sv
module vagg_ctrl
  import vagg_pkg::*;
#(
  parameter int NUM_VINT = 4,
  parameter int NUM_EVENTS = 64,
  parameter int ADDR_W = 16,
  localparam int EVT_W = $clog2(NUM_EVENTS),
  localparam int PAGE_W = ADDR_W - 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtNum,
  input  logic              evtDown,
  input  logic              cfgWrEn,
  input  logic [EVT_W-1:0]  cfgIdx,
  input  logic              cfgValid,
  input  logic              cfgLevel,
  input  logic [IDX_W-1:0]  cfgVint,
  input  logic [BIT_W-1:0]  cfgBit,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobe_t           strobe,
  output logic              evtError
);
  map_t mapQ [NUM_EVENTS];
  map_t entry;
  logic evtHit;
  logic [PAGE_W-1:0] page;
  logic [11:0] offset;
  logic pageOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EVENTS; i++) mapQ[i] <= '0;
      evtError <= 1'b0;
    end else begin
      if (cfgWrEn) mapQ[cfgIdx] <= '{valid: cfgValid, level: cfgLevel, vint: cfgVint, bitIdx: cfgBit};
      evtError <= evtValid && !evtHit;
    end
  end

  assign entry  = mapQ[evtNum];
  assign evtHit = evtValid && entry.valid && (int'(entry.vint) < NUM_VINT);
  assign page   = regAddr[ADDR_W-1:12];
  assign offset = regAddr[11:0];
  assign pageOk = int'(page) < NUM_VINT;

  always_comb begin
    strobe = '0;
    strobe.evtSet   = evtHit && !evtDown;
    strobe.evtClr   = evtHit && evtDown && entry.level;
    strobe.evtVint  = entry.vint;
    strobe.evtBit   = entry.bitIdx;
    strobe.pageVint = IDX_W'(page);
    strobe.rdSel    = RD_NONE;
    if (pageOk) begin
      unique case (offset)
        12'h000: begin strobe.enSet = regWrEn; strobe.rdSel = RD_ENABLE; end
        12'h008: begin strobe.enClr = regWrEn; strobe.rdSel = RD_ENABLE; end
        12'h018: begin strobe.ack   = regWrEn; strobe.rdSel = RD_RAW;    end
        12'h020: strobe.rdSel = RD_MASKED;
        default: strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vagg_datapath.sv
module vagg_datapath
  import vagg_pkg::*;
#(
  parameter int NUM_VINT = 4,
  localparam int SEL_W = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_VINT-1:0] vintIrq
);
  logic [DATA_W-1:0] statAll [NUM_VINT];
  logic [DATA_W-1:0] enAll   [NUM_VINT];
  logic [DATA_W-1:0] evtOne;

  assign evtOne = DATA_W'(1) << strobe.evtBit;

  for (genvar v = 0; v < NUM_VINT; v++) begin : gVint
    logic [DATA_W-1:0] statQ, enQ, statNext, enNext;
    logic evtHere, pageHere;

    assign evtHere  = strobe.evtVint == IDX_W'(v);
    assign pageHere = strobe.pageVint == IDX_W'(v);

    always_comb begin
      statNext = statQ;
      if (strobe.ack && pageHere) statNext = statNext & ~wrData;
      if (strobe.evtClr && evtHere) statNext = statNext & ~evtOne;
      if (strobe.evtSet && evtHere) statNext = statNext | evtOne;
      enNext = enQ;
      if (strobe.enSet && pageHere) enNext = enQ | wrData;
      else if (strobe.enClr && pageHere) enNext = enQ & ~wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statQ      <= '0;
        enQ        <= '0;
        vintIrq[v] <= 1'b0;
      end else begin
        statQ      <= statNext;
        enQ        <= enNext;
        vintIrq[v] <= |(statQ & enQ);
      end
    end

    assign statAll[v] = statQ;
    assign enAll[v]   = enQ;
  end

  logic [SEL_W-1:0] sel;
  assign sel = strobe.pageVint[SEL_W-1:0];

  always_comb begin
    unique case (strobe.rdSel)
      RD_ENABLE: rdData = enAll[sel];
      RD_RAW:    rdData = statAll[sel];
      RD_MASKED: rdData = statAll[sel] & enAll[sel];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/vint_aggregator.sv
module vint_aggregator
  import vagg_pkg::*;
#(
  parameter int NUM_VINT = 4,
  parameter int NUM_EVENTS = 64,
  parameter int ADDR_W = 16,
  localparam int EVT_W = $clog2(NUM_EVENTS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evtValid,
  input  logic [EVT_W-1:0]    evtNum,
  input  logic                evtDown,
  input  logic                cfgWrEn,
  input  logic [EVT_W-1:0]    cfgIdx,
  input  logic                cfgValid,
  input  logic                cfgLevel,
  input  logic [IDX_W-1:0]    cfgVint,
  input  logic [BIT_W-1:0]    cfgBit,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_VINT-1:0] vintIrq,
  output logic                evtError
);
  strobe_t strobe;

  vagg_ctrl #(.NUM_VINT(NUM_VINT), .NUM_EVENTS(NUM_EVENTS), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtNum(evtNum), .evtDown(evtDown),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgValid(cfgValid), .cfgLevel(cfgLevel),
    .cfgVint(cfgVint), .cfgBit(cfgBit), .regAddr(regAddr), .regWrEn(regWrEn),
    .strobe(strobe), .evtError(evtError)
  );

  vagg_datapath #(.NUM_VINT(NUM_VINT)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .rdData(regRdData), .vintIrq(vintIrq)
  );
endmodule

// File: rtl/vint_aggregator_chk.sv
module vint_aggregator_chk #(
  parameter int NUM_VINT = 4,
  parameter int ADDR_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                evtValid,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [63:0]         regRdData,
  input logic [NUM_VINT-1:0] vintIrq,
  input logic                evtError
);
  logic knownOff;
  assign knownOff = (regAddr[11:0] == 12'h000) || (regAddr[11:0] == 12'h008) ||
                    (regAddr[11:0] == 12'h018) || (regAddr[11:0] == 12'h020);

  // R8: the error pulse must follow an event
  assert_err_follows_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    evtError |-> $past(evtValid));

  // R9: a line rises only two cycles after a write or an event
  assert_irq_rise_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|(vintIrq & ~$past(vintIrq))) |-> ($past(regWrEn, 2) || $past(evtValid, 2)));

  // R9: a line stays high until a write or an event removes its cause
  assert_irq_fall_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|(~vintIrq & $past(vintIrq))) |-> ($past(regWrEn, 2) || $past(evtValid, 2)));

  // R11: unimplemented offsets read zero
  assert_unknown_offset_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !knownOff |-> (regRdData == 64'd0));

  // R11: pages beyond the vint count read zero
  assert_far_page_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr[ADDR_W-1:12]) >= NUM_VINT) |-> (regRdData == 64'd0));
endmodule

bind vint_aggregator vint_aggregator_chk #(.NUM_VINT(NUM_VINT), .ADDR_W(ADDR_W)) chkInst (.*);

// File: tb/vint_aggregator_test.sv
`timescale 1ns/1ps
module vint_aggregator_test;
  localparam int NV = 4;
  localparam int NE = 64;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 0, evtDown = 0, cfgWrEn = 0, cfgValid = 0, cfgLevel = 0, regWrEn = 0;
  logic [5:0] evtNum = 0, cfgIdx = 0, cfgBit = 0;
  logic [7:0] cfgVint = 0;
  logic [AW-1:0] regAddr = 0;
  logic [63:0] regWrData = 0;
  logic [63:0] regRdData;
  logic [NV-1:0] vintIrq;
  logic evtError;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vint_aggregator #(.NUM_VINT(NV), .NUM_EVENTS(NE), .ADDR_W(AW)) uut (.*);

  // behavioural reference model
  bit mValid [NE];
  bit mLevel [NE];
  int mVint [NE];
  int mBit [NE];
  logic [63:0] mStat [NV];
  logic [63:0] mEn [NV];
  logic [NV-1:0] mIrq;
  logic mErr;

  always @(posedge clk) begin
    logic [NV-1:0] nIrq;
    int pg, off;
    bit ok;
    if (!rstN) begin
      for (int i = 0; i < NE; i++) begin mValid[i] = 0; mLevel[i] = 0; mVint[i] = 0; mBit[i] = 0; end
      for (int v = 0; v < NV; v++) begin mStat[v] = 0; mEn[v] = 0; end
      mIrq = 0; mErr = 0;
    end else begin
      for (int v = 0; v < NV; v++) nIrq[v] = |(mStat[v] & mEn[v]);
      ok = evtValid && mValid[evtNum] && mVint[evtNum] < NV;
      mErr = evtValid && !ok;
      pg = int'(regAddr >> 12);
      off = int'(regAddr & 16'h0fff);
      if (regWrEn && pg < NV) begin
        if (off == 'h0) mEn[pg] = mEn[pg] | regWrData;
        else if (off == 'h8) mEn[pg] = mEn[pg] & ~regWrData;
        else if (off == 'h18) mStat[pg] = mStat[pg] & ~regWrData;
      end
      if (ok) begin
        if (evtDown && mLevel[evtNum]) mStat[mVint[evtNum]][mBit[evtNum]] = 1'b0;
        if (!evtDown) mStat[mVint[evtNum]][mBit[evtNum]] = 1'b1;
      end
      if (cfgWrEn) begin
        mValid[cfgIdx] = cfgValid; mLevel[cfgIdx] = cfgLevel;
        mVint[cfgIdx] = int'(cfgVint); mBit[cfgIdx] = int'(cfgBit);
      end
      mIrq = nIrq;
    end
  end

  function automatic logic [63:0] mRead(input logic [AW-1:0] a);
    int pg = int'(a >> 12);
    int off = int'(a & 16'h0fff);
    if (pg >= NV) return 64'd0;
    case (off)
      'h0, 'h8: return mEn[pg];
      'h18: return mStat[pg];
      'h20: return mStat[pg] & mEn[pg];
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input bit good, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison of the outputs (R9 lines, R8 error pulse)
  always @(negedge clk) if (rstN && !done) begin
    chk(vintIrq === mIrq, "R9 irq lines", 64'(vintIrq), 64'(mIrq));
    chk(evtError === mErr, "R8 error pulse", 64'(evtError), 64'(mErr));
  end

  task automatic idle();
    evtValid = 0; evtDown = 0; cfgWrEn = 0; regWrEn = 0;
  endtask

  task automatic mapSet(input int idx, input bit vld, input bit lvl, input int vi, input int b);
    @(negedge clk); idle();
    cfgWrEn = 1; cfgIdx = 6'(idx); cfgValid = vld; cfgLevel = lvl; cfgVint = 8'(vi); cfgBit = 6'(b);
    @(negedge clk); idle();
  endtask

  task automatic evt(input int n, input bit down);
    @(negedge clk); idle();
    evtValid = 1; evtNum = 6'(n); evtDown = down;
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk); idle();
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(negedge clk); idle();
    regAddr = a; #1;
    chk(regRdData === mRead(a), tag, regRdData, mRead(a));
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R12 reset state
    rd(16'h0000, "R12 enable reset");
    rd(16'h3018, "R12 status reset");
    chk(vintIrq === '0, "R12 irq reset", 64'(vintIrq), 0);
    chk(regRdData === 64'd0, "R12 read zero", regRdData, 0);

    mapSet(3, 1, 0, 0, 5);
    mapSet(10, 1, 1, 2, 63);
    mapSet(20, 1, 0, 3, 0);
    mapSet(7, 1, 0, 5, 1);    // vint out of range
    mapSet(12, 1, 1, 1, 17);

    // R6 edge event
    evt(3, 0); settle();
    rd(16'h0018, "R6 edge set raw");
    chk(regRdData === 64'h20, "R6 edge bit 5", regRdData, 64'h20);
    rd(16'h0020, "R4 masked while disabled");
    rd(16'h1018, "R5 other page untouched");
    // R1 enable set
    wr(16'h0000, 64'h21); settle();
    rd(16'h0000, "R1 enable read");
    rd(16'h0008, "R1 enable read at clear offset");
    rd(16'h0020, "R4 masked pending");
    wr(16'h0000, 64'h0); settle();
    rd(16'h0000, "R1 zero write no change");
    // R6 down on edge source: no effect
    evt(3, 1); settle();
    rd(16'h0018, "R6 edge down ignored");
    // R4 write to masked ignored
    wr(16'h0020, 64'hffff_ffff_ffff_ffff); settle();
    rd(16'h0018, "R4 masked write ignored raw");
    rd(16'h0000, "R4 masked write ignored en");
    // R3 acknowledge
    wr(16'h0018, 64'h20); settle();
    rd(16'h0018, "R3 ack cleared");
    // R7 level up/down
    wr(16'h2000, 64'h8000_0000_0000_0000);
    evt(10, 0); settle();
    rd(16'h2020, "R7 level up");
    chk(vintIrq[2] === 1'b1, "R7 irq high", 64'(vintIrq), 64'h4);
    evt(10, 1); settle();
    rd(16'h2018, "R7 level down");
    chk(vintIrq[2] === 1'b0, "R7 irq low", 64'(vintIrq), 0);
    // level on vint1 with pulses back to back
    wr(16'h1000, 64'h2_0000);
    evt(12, 0); evt(12, 0); settle();
    rd(16'h1020, "R7 repeated up");
    // R8 dropped events
    evt(30, 0); settle();
    evt(7, 0); settle();
    rd(16'h3018, "R8 dropped no status");
    rd(16'h0018, "R8 dropped no status v0");
    // R10 set wins over ack in same cycle
    wr(16'h3000, 64'h1);
    @(negedge clk); idle();
    evtValid = 1; evtNum = 6'd20; evtDown = 0;
    regWrEn = 1; regAddr = 16'h3018; regWrData = 64'h1;
    @(negedge clk); idle(); settle();
    rd(16'h3018, "R10 set beats ack");
    chk(regRdData === 64'h1, "R10 bit kept", regRdData, 64'h1);
    // R2 enable clear
    wr(16'h3008, 64'h1); settle();
    rd(16'h3000, "R2 enable cleared");
    rd(16'h3020, "R2 masked cleared");
    // R11 unimplemented offset and far page
    wr(16'h0010, 64'hffff); settle();
    rd(16'h0010, "R11 hole reads zero");
    rd(16'h0000, "R11 hole write ignored");
    wr(16'h5000, 64'hffff); wr(16'h5018, 64'hffff); settle();
    rd(16'h5000, "R11 far page zero");
    for (int v = 0; v < NV; v++) rd(16'(v << 12), "R11 far write ignored");
    rd(16'h1018, "R5 vint1 raw");
    // remap an entry and reuse (R6)
    mapSet(3, 0, 0, 0, 5);
    evt(3, 0); settle();
    rd(16'h0018, "R8 invalidated entry");
    settle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule